// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a small pipelined synchronous static RAM. Reads and writes can follow one another on every clock edge with no idle slot between them. The data path is 36 bits wide, organised as four byte lanes of 9 bits each. The on-chip array holds 256 words by default. Every control input, the address and the write data are sampled on the rising edge of one clock. Read data leaves through an output register, and an asynchronous active-low drive enable gates it.

A host starts an access by loading an address, and fixes the access as a read or a write at that same moment. It can then step through up to four consecutive words by asking for a continuation. The two low address bits then come from an internal 2-bit sequencer, in ascending or XOR order. Write data lags its address by two enabled edges, which is a late-write scheme. The block forwards pending write data, lane by lane, to any read that overtakes it, so a read issued straight after a write to the same word returns the new contents. A suspend input freezes the whole block. Three chip-select inputs must all agree before an access is accepted, and a doze input refuses new accesses.

Top module: `zt_sram`

## Requirements
- R1: After a synchronous reset, `rdata_vld` is low and no access is in flight.
- R2: A read loaded while `cont`=0 (with `rd_nwr`=1) shows the word at `addr` on `rdata` after the second enabled rising edge from the load edge, with `rdata_vld` high.
- R3: With `order_xor`=0, each `cont`=1 beat of an active burst sets the two low address bits to the loaded low bits plus 1, 2 and 3 (mod 4) in turn. The upper bits stay as loaded.
- R4: With `order_xor`=1, the burst beats use the loaded low bits XOR 1, XOR 2 and XOR 3.
- R5: A write takes `wdata` at the second enabled edge after its address edge. Lane k is bits [9k+8:9k] and is written only when `lane_wr_n[k]`=0, where `lane_wr_n` is sampled with the address.
- R6: Reads and writes can alternate on every edge. A read returns any earlier write to the same word that is not yet in the array, merged lane by lane over the stored data.
- R7: While `suspend`=1, a rising edge has no effect. Outputs, the pipeline, the burst position and the pending write data all hold.
- R8: A load is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A deselected load, and the continuation beats that follow it, neither read nor write.
- R9: `drive_n`=1 forces `rdata_vld` low and `rdata` to zero at once, without disturbing the pipeline.
- R10: While `doze`=1, an edge accepts no new access and ends any burst. Later `cont`=1 beats access nothing until a new load.
- R11: The read or write type is fixed at the load. `rd_nwr` is ignored on continuation beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | 1 = ignore this clock edge |
| cont | input | 1 | 0 = load a new address, 1 = next burst beat |
| rd_nwr | input | 1 | Access type at load: 1 read, 0 write |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| doze | input | 1 | Low-power request, refuses new accesses |
| order_xor | input | 1 | Burst order: 0 ascending, 1 XOR |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, two enabled edges after its address |
| drive_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read data, zero when not driven |
| rdata_vld | output | 1 | Read data valid and driven |

## Verification
The case that matters most is a read that reaches the output stage in the same edge as an older write to the same word, whose data is only now arriving and has not yet reached the array. The bench provokes this by issuing write and read loads to one address on adjacent edges, with partial lane masks, and by alternating them without a gap. A behavioural program-order memory model in the bench predicts each output word, and the result is compared lane for lane on every clock. A second overlap, suspend falling in the middle of a burst while the pipeline is full, is checked by holding the suspend for several edges and requiring that output and burst order come out unchanged.

// File: rtl/zt_pkg.sv
package zt_pkg;

  // Low two address bits for beat number 'step' of a burst that began at 'start'.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       use_xor);
    logic [1:0] r;
    if (use_xor) r = start ^ step;
    else         r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
  parameter int AW = 8,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cont,
  input  logic          rd_nwr,
  input  logic          sel,
  input  logic          doze,
  input  logic          order_xor,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] lane_wr_n,
  output logic          op_vld,
  output logic          op_rd,
  output logic [AW-1:0] op_addr,
  output logic [NL-1:0] op_be
);
  import zt_pkg::*;

  logic          active;
  logic          type_rd;
  logic [AW-1:0] base;
  logic [1:0]    beat;
  logic [1:0]    beat_nx;

  assign beat_nx = beat + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      type_rd <= 1'b1;
      base    <= '0;
      beat    <= '0;
      op_vld  <= 1'b0;
      op_rd   <= 1'b1;
      op_addr <= '0;
      op_be   <= '0;
    end else if (en) begin
      op_be <= ~lane_wr_n;
      if (doze) begin
        active <= 1'b0;
        op_vld <= 1'b0;
      end else if (!cont) begin
        active  <= sel;
        op_vld  <= sel;
        type_rd <= rd_nwr;
        op_rd   <= rd_nwr;
        base    <= addr;
        beat    <= 2'd0;
        op_addr <= addr;
      end else if (active) begin
        beat    <= beat_nx;
        op_vld  <= 1'b1;
        op_rd   <= type_rd;
        op_addr <= {base[AW-1:2], burst_lo(base[1:0], beat_nx, order_xor)};
      end else begin
        op_vld <= 1'b0;
      end
    end
  end

  // R3 / R4: every continuation beat of a live burst moves the position by one
  p_burst_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && cont && active && !doze) |=> (beat == $past(beat) + 2'd1));

  // R10: a dozing edge never launches an access
  p_doze_block_r10: assert property (@(posedge clk) disable iff (rst)
    (en && doze) |=> !op_vld);

  // R8: a load without all three selects launches nothing
  p_desel_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !cont && !sel) |=> !op_vld);

  // R11: the access type stays put along a burst
  p_type_fixed_r11: assert property (@(posedge clk) disable iff (rst)
    (en && cont && active && !doze && op_vld) |=> (op_rd == $past(op_rd)));

endmodule

// File: rtl/zt_lane_ram.sv
module zt_lane_ram #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port, read-before-write: suitable for block RAM inference.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/zt_fwd_merge.sv
module zt_fwd_merge #(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic [AW-1:0]    rd_addr,
  input  logic [NL*LW-1:0] arr_data,
  input  logic             pw_vld,
  input  logic [AW-1:0]    pw_addr,
  input  logic [NL-1:0]    pw_be,
  input  logic [NL*LW-1:0] pw_data,
  output logic [NL*LW-1:0] merged
);
  logic same_word;

  assign same_word = pw_vld && (pw_addr == rd_addr);

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign merged[k*LW +: LW] = (same_word && pw_be[k]) ? pw_data[k*LW +: LW]
                                                        : arr_data[k*LW +: LW];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             suspend,
  input  logic             cont,
  input  logic             rd_nwr,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             doze,
  input  logic             order_xor,
  input  logic [NL-1:0]    lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [NL*LW-1:0] wdata,
  input  logic             drive_n,
  output logic [NL*LW-1:0] rdata,
  output logic             rdata_vld
);
  localparam int DW = NL * LW;

  logic          en;
  logic          sel;

  // stage 1: access accepted at the last enabled edge
  logic          s1_vld, s1_rd;
  logic [AW-1:0] s1_addr;
  logic [NL-1:0] s1_be;

  // stage 2: access waiting for write data or for the output register
  logic          s2_vld, s2_rd;
  logic [AW-1:0] s2_addr;
  logic [NL-1:0] s2_be;

  // write retired at the last enabled edge, not yet visible through the array port
  logic          pw_vld;
  logic [AW-1:0] pw_addr;
  logic [NL-1:0] pw_be;
  logic [DW-1:0] pw_data;

  logic          commit;
  logic [DW-1:0] arr_q;
  logic [DW-1:0] merged;
  logic          out_vld;
  logic [DW-1:0] out_q;

  assign en     = !suspend;
  assign sel    = !cs_a_n && cs_b && !cs_c_n;
  assign commit = s2_vld && !s2_rd;

  zt_burst_seq #(.AW(AW), .NL(NL)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cont      (cont),
    .rd_nwr    (rd_nwr),
    .sel       (sel),
    .doze      (doze),
    .order_xor (order_xor),
    .addr      (addr),
    .lane_wr_n (lane_wr_n),
    .op_vld    (s1_vld),
    .op_rd     (s1_rd),
    .op_addr   (s1_addr),
    .op_be     (s1_be)
  );

  for (genvar k = 0; k < NL; k++) begin : g_ram
    zt_lane_ram #(.AW(AW), .W(LW)) u_ram (
      .clk   (clk),
      .en    (en),
      .we    (commit && s2_be[k]),
      .waddr (s2_addr),
      .wdata (wdata[k*LW +: LW]),
      .raddr (s1_addr),
      .rdata (arr_q[k*LW +: LW])
    );
  end

  zt_fwd_merge #(.AW(AW), .NL(NL), .LW(LW)) u_fwd (
    .rd_addr  (s2_addr),
    .arr_data (arr_q),
    .pw_vld   (pw_vld),
    .pw_addr  (pw_addr),
    .pw_be    (pw_be),
    .pw_data  (pw_data),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_rd   <= 1'b1;
      s2_addr <= '0;
      s2_be   <= '0;
      pw_vld  <= 1'b0;
      pw_addr <= '0;
      pw_be   <= '0;
      pw_data <= '0;
      out_vld <= 1'b0;
      out_q   <= '0;
    end else if (en) begin
      s2_vld  <= s1_vld;
      s2_rd   <= s1_rd;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      pw_vld  <= commit;
      pw_addr <= s2_addr;
      pw_be   <= s2_be;
      pw_data <= wdata;
      out_vld <= s2_vld && s2_rd;
      if (s2_vld && s2_rd) out_q <= merged;
    end
  end

  assign rdata_vld = out_vld && !drive_n;
  assign rdata     = rdata_vld ? out_q : '0;

  // R7: a suspended edge leaves output and pipeline untouched
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    suspend |=> ($stable(out_q) && $stable(out_vld) && $stable(s2_addr) && $stable(pw_vld)));

  // R2: a read in the second stage always reaches the output register
  p_read_out_r2: assert property (@(posedge clk) disable iff (rst)
    (en && s2_vld && s2_rd) |=> out_vld);

  // R5: an edge that retires nothing leaves no pending write behind
  p_no_phantom_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !s2_vld) |=> !pw_vld);

endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int CLK_P = 10;
  localparam logic [2:0] SEL = 3'b010;  // {cs_a_n, cs_b, cs_c_n}

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        suspend = 1'b0, cont = 1'b0, rd_nwr = 1'b1;
  logic        cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic        doze = 1'b0, order_xor = 1'b0, drive_n = 1'b0;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_vld;

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R1";
  logic [35:0] dp0 = '0, dp1 = '0;

  always #(CLK_P/2) clk = ~clk;

  zt_sram uut (
    .clk(clk), .rst(rst), .suspend(suspend), .cont(cont), .rd_nwr(rd_nwr),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .doze(doze),
    .order_xor(order_xor), .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata),
    .drive_n(drive_n), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  // ---------------- behavioural reference ----------------
  typedef struct { bit v; bit rd; int a; bit [3:0] be; } op_t;
  op_t         pq[$];
  logic [35:0] mm [256];
  bit          m_act, m_rd;
  int          m_base, m_cnt;
  bit          e_v;
  logic [35:0] e_q;

  always begin
    @(posedge clk);
    if (rst) begin
      op_t z;
      z = '{v:0, rd:0, a:0, be:0};
      pq = '{z, z};
      m_act = 0; e_v = 0; e_q = '0;
    end else if (!suspend) begin
      op_t o, nw;
      int lo;
      nw = '{v:0, rd:0, a:0, be:~lane_wr_n};
      if (doze) m_act = 0;
      else if (!cont) begin
        m_act  = ({cs_a_n, cs_b, cs_c_n} == SEL);
        m_rd   = rd_nwr;
        m_base = int'(addr);
        m_cnt  = 0;
        nw.v = m_act; nw.rd = m_rd; nw.a = m_base;
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4;
        lo = order_xor ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        nw.v = 1; nw.rd = m_rd; nw.a = (m_base / 4) * 4 + lo;
      end
      o = pq.pop_front();
      if (o.v && !o.rd)
        for (int k = 0; k < 4; k++) if (o.be[k]) mm[o.a][k*9 +: 9] = wdata[k*9 +: 9];
      e_v = o.v && o.rd;
      if (e_v) e_q = mm[o.a];
      pq.push_back(nw);
    end
    #(CLK_P/4);
    if (!rst) begin
      bit exp_en;
      exp_en = e_v && !drive_n;
      n_chk++;
      if (rdata_vld !== exp_en || (exp_en && rdata !== e_q)) begin
        n_bad++;
        $display("FAIL %s model: vld=%b q=%h exp vld=%b q=%h", cur_tag, rdata_vld, rdata, exp_en, e_q);
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [35:0] pat(input int a);
    logic [7:0] b;
    b = a[7:0];
    return {1'b0, b, 1'b1, ~b, 1'b0, b + 8'd3, 1'b1, b ^ 8'hC3};
  endfunction

  function automatic logic [35:0] lmask(input logic [3:0] bwn);
    logic [35:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) if (!bwn[k]) m[k*9 +: 9] = '1;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit adv, input bit rw, input int a, input logic [3:0] bwn,
                      input logic [35:0] d, input logic [2:0] cs, input bit sus, input bit slp);
    @(negedge clk);
    suspend = sus; cont = adv; rd_nwr = rw; addr = a[7:0]; lane_wr_n = bwn;
    {cs_a_n, cs_b, cs_c_n} = cs; doze = slp;
    if (!sus) begin wdata = dp1; dp1 = dp0; dp0 = d; end
    @(posedge clk);
    #(CLK_P/4 + 1);
  endtask

  task automatic ld(input bit rw, input int a, input logic [3:0] bwn, input logic [35:0] d);
    step(1'b0, rw, a, bwn, d, SEL, 1'b0, 1'b0);
  endtask

  task automatic beat(input bit rw, input logic [35:0] d);
    step(1'b1, rw, 0, 4'h0, d, SEL, 1'b0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 0, 4'hF, '0, 3'b110, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] d1, d2, wd;
    int la[4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #(CLK_P/4 + 1);
    chk("R1 reset valid", {35'd0, rdata_vld}, 36'd0);

    cur_tag = "R5 fill";
    for (int i = 0; i < 256; i++) ld(1'b0, i, 4'h0, pat(i));
    idle(); idle();

    cur_tag = "R2";
    ld(1'b1, 5, 4'hF, '0); ld(1'b1, 200, 4'hF, '0);
    idle(); chk("R2 read 5", rdata, pat(5));
    idle(); chk("R2 read 200", rdata, pat(200));

    cur_tag = "R3";
    order_xor = 1'b0;
    la = '{'h12, 'h13, 'h10, 'h11};
    ld(1'b1, 'h12, 4'hF, '0); beat(1'b1, '0);
    for (int i = 0; i < 4; i++) begin
      if (i < 2) beat(1'b1, '0); else idle();
      chk("R3 ascending beat", rdata, pat(la[i]));
    end

    cur_tag = "R4";
    order_xor = 1'b1;
    la = '{'h21, 'h20, 'h23, 'h22};
    ld(1'b1, 'h21, 4'hF, '0); beat(1'b1, '0);
    for (int i = 0; i < 4; i++) begin
      if (i < 2) beat(1'b1, '0); else idle();
      chk("R4 xor beat", rdata, pat(la[i]));
    end
    order_xor = 1'b0;

    cur_tag = "R5";
    wd = 36'h9_2468_ACE1;
    ld(1'b0, 'h30, 4'b1010, wd); idle(); idle(); idle();
    ld(1'b1, 'h30, 4'hF, '0); idle(); idle();
    chk("R5 lane write", rdata, (wd & lmask(4'b1010)) | (pat('h30) & ~lmask(4'b1010)));

    cur_tag = "R6";
    d1 = 36'hA_5A5A_5A5A; d2 = 36'h3_C3C3_C3C3;
    ld(1'b0, 'h40, 4'b0110, d1); ld(1'b1, 'h40, 4'hF, '0);
    ld(1'b0, 'h41, 4'b0000, d2); ld(1'b1, 'h41, 4'hF, '0);
    chk("R6 forwarded merge", rdata, (d1 & lmask(4'b0110)) | (pat('h40) & ~lmask(4'b0110)));
    idle(); chk("R6 write slot idle", {35'd0, rdata_vld}, 36'd0);
    idle(); chk("R6 forwarded full", rdata, d2);
    for (int i = 0; i < 6; i++) begin
      ld(1'b0, 'h42, {2'b00, i[0], ~i[0]}, 36'h1_0000_0000 + 36'(i * 'h1357));
      ld(1'b1, 'h42, 4'hF, '0);
    end
    idle(); idle();

    cur_tag = "R7";
    ld(1'b1, 'h50, 4'hF, '0); beat(1'b1, '0); beat(1'b1, '0);
    chk("R7 before hold", rdata, pat('h50));
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 'hAA, 4'h0, 36'hF_FFFF_FFFF, SEL, 1'b1, 1'b0);
      chk("R7 held data", rdata, pat('h50));
      chk("R7 held valid", {35'd0, rdata_vld}, 36'd1);
    end
    beat(1'b1, '0); chk("R7 resume 1", rdata, pat('h51));
    idle(); chk("R7 resume 2", rdata, pat('h52));
    idle(); chk("R7 resume 3", rdata, pat('h53));

    cur_tag = "R8";
    la = '{'h60, 'h64, 'h68, 0};
    for (int i = 0; i < 3; i++) begin
      logic [2:0] cs;
      cs = (i == 0) ? 3'b110 : (i == 1) ? 3'b000 : 3'b011;
      step(1'b0, 1'b0, la[i], 4'h0, 36'hF_0F0F_0F0F, cs, 1'b0, 1'b0);
      beat(1'b0, 36'hE_EEEE_EEEE); beat(1'b0, 36'hD_DDDD_DDDD);
      idle(); idle();
      ld(1'b1, la[i], 4'hF, '0); ld(1'b1, la[i] + 1, 4'hF, '0);
      idle(); chk("R8 deselected load", rdata, pat(la[i]));
      idle(); chk("R8 dead beat", rdata, pat(la[i] + 1));
    end

    cur_tag = "R9";
    ld(1'b1, 'h70, 4'hF, '0); idle(); idle();
    drive_n = 1'b1; #1;
    chk("R9 undriven valid", {35'd0, rdata_vld}, 36'd0);
    chk("R9 undriven data", rdata, 36'd0);
    drive_n = 1'b0; #1;
    chk("R9 driven again", rdata, pat('h70));

    cur_tag = "R10";
    step(1'b0, 1'b0, 'h74, 4'h0, 36'h0_1111_1111, SEL, 1'b0, 1'b1);
    idle(); idle();
    ld(1'b1, 'h78, 4'hF, '0);
    step(1'b1, 1'b1, 0, 4'hF, '0, SEL, 1'b0, 1'b1);
    beat(1'b1, '0); chk("R10 first beat", rdata, pat('h78));
    beat(1'b1, '0); chk("R10 dozing beat", {35'd0, rdata_vld}, 36'd0);
    idle(); chk("R10 burst ended", {35'd0, rdata_vld}, 36'd0);
    idle();
    ld(1'b1, 'h74, 4'hF, '0); idle(); idle();
    chk("R10 refused write", rdata, pat('h74));

    cur_tag = "R11";
    ld(1'b0, 'h7C, 4'h0, 36'h9_0000_0000);
    for (int i = 1; i < 4; i++) beat(1'b1, 36'h9_0000_0000 + 36'(i * 'h1111));
    idle(); idle();
    ld(1'b1, 'h7C, 4'hF, '0); ld(1'b1, 'h7D, 4'hF, '0); ld(1'b1, 'h7E, 4'hF, '0);
    chk("R11 beat 0", rdata, 36'h9_0000_0000);
    ld(1'b1, 'h7F, 4'hF, '0); chk("R11 beat 1", rdata, 36'h9_0000_1111);
    idle(); chk("R11 beat 2", rdata, 36'h9_0000_2222);
    idle(); chk("R11 beat 3", rdata, 36'h9_0000_3333);
    idle();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule